// File: doc/BRIEF.md
# Parallel Preamble Acquisition Correlator

This block sits behind a deserializer that delivers one in-phase and one quadrature hard-decision word per clock, with the earliest chip of each word in its most significant bit. It searches every accepted word for a known training sequence. The search covers all four 90° phase rotations of the carrier and all bit alignments inside a word. Every clock it scores `4 × W` hypotheses in parallel.

When the best score exceeds a programmable signed threshold, the block emits a one-cycle detect pulse and reports the winning rotation and bit offset. It then locks. While locked, each accepted word yields one output word pair. That pair is cut on the transmitter's word boundaries and rotated back to the reference phase, ready for a decoder.

A frame-end input releases the lock and restarts the search. The sequence length is a parameter, so the bench can use a short sequence.

Top module: `preamble_acq`

## Requirements
- R1: After reset, `frame_det` and `out_valid` are low, and `det_phase`, `det_offset`, `out_i` and `out_q` are zero.
- R2: The I reference is produced by a shift register of `LFSR_DEG` bits.
  - It starts from all ones.
  - Each step emits the register's top bit as the next chip, shifts left, and inserts the parity of (register AND `LFSR_TAPS`) at bit 0.
  - The Q reference is produced the same way from `Q_SEED`.
  - Both references are `SEQ_LEN` chips long, and `SEQ_LEN` is a multiple of `W`.
- R3: Hypothesis scoring works as follows.
  - The score of a hypothesis is (agreeing chips − disagreeing chips), counted over I and Q, so it ranges over ±2·`SEQ_LEN`.
  - A frame is detected when the winning score is strictly greater than the signed `threshold`.
  - `frame_det` is high for exactly one cycle, two rising edges after the edge that accepted the word completing the search window.
- R4: Phase hypothesis `k` (0..3) assumes that the received pair equals the reference rotated `k` times by the map (I,Q)→(¬Q,I). `det_phase` reports `k`.
- R5: `det_offset` is the position of the first training chip within its word, counted from the MSB (0..W−1).
- R6: The winner is the hypothesis with the largest score. Ties go to the lowest phase, then to the lowest offset.
- R7: After a detection the block is locked.
  - No further `frame_det` pulse is produced.
  - `det_phase` and `det_offset` hold their values until `frame_end`.
- R8: `frame_end` releases the lock. A detection that would occur in the same cycle as `frame_end` is suppressed.
- R9: While locked, each accepted word produces one output word pair one edge later, with `out_valid` high for one cycle.
  - Output word `j` holds payload chips `j·W` .. `j·W+W−1`, MSB first.
  - The payload starts at the chip right after the training sequence.
  - Output chips are rotated back by the detected phase.
- R10: With `in_valid` low, the search history does not advance, no hypothesis is evaluated and no output is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input words valid this cycle |
| in_i | input | W | In-phase hard decisions, earliest chip in the MSB |
| in_q | input | W | Quadrature hard decisions, earliest chip in the MSB |
| frame_end | input | 1 | Releases the lock and rearms the search |
| threshold | input | $clog2(2·SEQ_LEN)+2 | Signed detection threshold |
| frame_det | output | 1 | One-cycle frame detection pulse |
| det_phase | output | 2 | Detected rotation index |
| det_offset | output | $clog2(W) | Detected chip offset within the word |
| out_valid | output | 1 | Aligned output words valid |
| out_i | output | W | Realigned, phase-corrected in-phase word |
| out_q | output | W | Realigned, phase-corrected quadrature word |

## Verification
The embedded properties check, on every cycle, the following:
- the detect pulse lasts one cycle;
- the detect pulse never occurs without a word accepted two edges earlier;
- the detect pulse never follows a `frame_end`;
- the reported phase and offset stay fixed while locked;
- the history freezes when no word is accepted;
- outputs appear only for accepted words.

Only the directed scenarios can show the following:
- that the search finds the right rotation and offset for real streams;
- that tie-breaking picks the lowest phase and offset;
- that output words carry exactly the payload chips, correctly derotated.

The bench computes these independently from the reference recurrence and the scoring rule.

// File: rtl/pa_pkg.sv
package pa_pkg;
    localparam int PA_PHASES = 4;
    typedef logic [1:0] pa_phase_t;

    // Rotate one chip pair back to reference phase: undoes k steps of (I,Q)->(~Q,I)
    function automatic logic [1:0] pa_derotate(input pa_phase_t k, input logic ci, input logic cq);
        logic [1:0] r;
        case (k)
            2'd0:    r = {ci, cq};
            2'd1:    r = {cq, ~ci};
            2'd2:    r = {~ci, ~cq};
            default: r = {~cq, ci};
        endcase
        return r;
    endfunction
endpackage

// File: rtl/pa_history.sv
module pa_history #(
    parameter int W     = 32,
    parameter int DEPTH = 33
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic [W-1:0]      in_i,
    input  logic [W-1:0]      in_q,
    output logic [W*DEPTH-1:0] hist_i,
    output logic [W*DEPTH-1:0] hist_q
);
    localparam int HB = W * DEPTH;

    typedef struct packed {
        logic [HB-1:0] hi;
        logic [HB-1:0] hq;
    } hist_t;

    hist_t st_d, st_q;

    // Oldest word at the top, newest word in the low W bits
    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.hi = {st_q.hi[HB-W-1:0], in_i};
            st_d.hq = {st_q.hq[HB-W-1:0], in_q};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hist_i = st_q.hi;
    assign hist_q = st_q.hq;

    p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> ($stable(hist_i) && $stable(hist_q)));
endmodule

// File: rtl/pa_corr_bank.sv
module pa_corr_bank #(
    parameter int                    W         = 32,
    parameter int                    SEQ_LEN   = 1024,
    parameter int                    LFSR_DEG  = 10,
    parameter logic [LFSR_DEG-1:0]   LFSR_TAPS = 10'h240,
    parameter logic [LFSR_DEG-1:0]   Q_SEED    = 10'h155,
    parameter int                    MW        = 13
) (
    input  logic [W*(SEQ_LEN/W+1)-1:0]   hist_i,
    input  logic [W*(SEQ_LEN/W+1)-1:0]   hist_q,
    output logic [4*W*MW-1:0]            metrics
);
    localparam int HB = W * (SEQ_LEN / W + 1);

    // Training chips, first chip at the MSB
    function automatic logic [SEQ_LEN-1:0] gen_ref(input logic [LFSR_DEG-1:0] seed);
        logic [SEQ_LEN-1:0]  r;
        logic [LFSR_DEG-1:0] sr;
        r  = '0;
        sr = seed;
        for (int k = 0; k < SEQ_LEN; k++) begin
            r[SEQ_LEN-1-k] = sr[LFSR_DEG-1];
            sr = {sr[LFSR_DEG-2:0], ^(sr & LFSR_TAPS)};
        end
        return r;
    endfunction

    localparam logic [SEQ_LEN-1:0] REF_I = gen_ref({LFSR_DEG{1'b1}});
    localparam logic [SEQ_LEN-1:0] REF_Q = gen_ref(Q_SEED);

    // Reference after k forward rotations (I,Q)->(~Q,I); sel_q picks the branch
    function automatic logic [SEQ_LEN-1:0] rot_ref(input int k, input bit sel_q);
        logic [SEQ_LEN-1:0] ri, rq, t;
        ri = REF_I;
        rq = REF_Q;
        for (int n = 0; n < k; n++) begin
            t  = ~rq;
            rq = ri;
            ri = t;
        end
        return sel_q ? rq : ri;
    endfunction

    for (genvar p = 0; p < 4; p++) begin : g_phase
        localparam logic [SEQ_LEN-1:0] RI = rot_ref(p, 1'b0);
        localparam logic [SEQ_LEN-1:0] RQ = rot_ref(p, 1'b1);
        for (genvar s = 0; s < W; s++) begin : g_off
            logic [SEQ_LEN-1:0] win_i, win_q;
            logic [MW-1:0]      score;
            int                 agree;
            assign win_i = hist_i[HB-1-s -: SEQ_LEN];
            assign win_q = hist_q[HB-1-s -: SEQ_LEN];
            always_comb begin
                agree = $countones(~(win_i ^ RI)) + $countones(~(win_q ^ RQ));
                score = MW'(2 * agree - 2 * SEQ_LEN);
            end
            assign metrics[(p*W+s)*MW +: MW] = score;
        end
    end
endmodule

// File: rtl/pa_arbiter.sv
module pa_arbiter #(
    parameter int W  = 32,
    parameter int MW = 13
) (
    input  logic [4*W*MW-1:0]     metrics,
    input  logic signed [MW-1:0]  thr,
    output logic                  hit,
    output logic [1:0]            win_phase,
    output logic [$clog2(W)-1:0]  win_offset
);
    localparam int NH = 4 * W;
    localparam int IW = $clog2(NH);

    logic signed [MW-1:0] best, cand;
    logic [IW-1:0]        best_idx;

    // Phase-major scan with strict compare: equal scores keep the earlier index
    always_comb begin
        best     = signed'(metrics[MW-1:0]);
        best_idx = '0;
        for (int h = 1; h < NH; h++) begin
            cand = signed'(metrics[h*MW +: MW]);
            if (cand > best) begin
                best     = cand;
                best_idx = IW'(h);
            end
        end
    end

    assign hit        = best > thr;
    assign win_phase  = best_idx[IW-1 -: 2];
    assign win_offset = best_idx[$clog2(W)-1:0];
endmodule

// File: rtl/pa_realign.sv
module pa_realign
    import pa_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  pa_phase_t            phase,
    input  logic [$clog2(W)-1:0] offset,
    input  logic [W-1:0]         prev_i,
    input  logic [W-1:0]         prev_q,
    input  logic [W-1:0]         new_i,
    input  logic [W-1:0]         new_q,
    output logic                 out_valid,
    output logic [W-1:0]         out_i,
    output logic [W-1:0]         out_q
);
    typedef struct packed {
        logic         vld;
        logic [W-1:0] oi;
        logic [W-1:0] oq;
    } ra_t;

    ra_t st_d, st_q;
    logic [2*W-1:0] cat_i, cat_q;
    logic [W-1:0]   sl_i, sl_q;
    logic [1:0]     pair;

    assign cat_i = {prev_i, new_i};
    assign cat_q = {prev_q, new_q};
    assign sl_i  = cat_i[2*W-1-offset -: W];
    assign sl_q  = cat_q[2*W-1-offset -: W];

    always_comb begin
        st_d     = st_q;
        st_d.vld = en;
        pair     = '0;
        if (en) begin
            for (int b = 0; b < W; b++) begin
                pair       = pa_derotate(phase, sl_i[b], sl_q[b]);
                st_d.oi[b] = pair[1];
                st_d.oq[b] = pair[0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_i     = st_q.oi;
    assign out_q     = st_q.oq;

    p_hold_data_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(out_i) && $stable(out_q)));
endmodule

// File: rtl/preamble_acq.sv
module preamble_acq
    import pa_pkg::*;
#(
    parameter int                   W         = 32,
    parameter int                   SEQ_LEN   = 1024,
    parameter int                   LFSR_DEG  = 10,
    parameter logic [LFSR_DEG-1:0]  LFSR_TAPS = 10'h240,
    parameter logic [LFSR_DEG-1:0]  Q_SEED    = 10'h155,
    localparam int                  MW        = $clog2(2 * SEQ_LEN) + 2,
    localparam int                  OW        = $clog2(W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [W-1:0]         in_i,
    input  logic [W-1:0]         in_q,
    input  logic                 frame_end,
    input  logic signed [MW-1:0] threshold,
    output logic                 frame_det,
    output logic [1:0]           det_phase,
    output logic [OW-1:0]        det_offset,
    output logic                 out_valid,
    output logic [W-1:0]         out_i,
    output logic [W-1:0]         out_q
);
    localparam int DEPTH = SEQ_LEN / W + 1;
    localparam int HB    = W * DEPTH;

    typedef struct packed {
        logic          locked;
        logic          fresh;
        logic          det;
        pa_phase_t     phase;
        logic [OW-1:0] offset;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic [HB-1:0]       hist_i, hist_q;
    logic [4*W*MW-1:0]   metrics;
    logic                arb_hit, hit_now, ra_en;
    pa_phase_t           win_phase, use_phase;
    logic [OW-1:0]       win_offset, use_offset;

    pa_history #(.W(W), .DEPTH(DEPTH)) u_hist (
        .clk(clk), .rst_n(rst_n), .shift_en(in_valid),
        .in_i(in_i), .in_q(in_q), .hist_i(hist_i), .hist_q(hist_q)
    );

    pa_corr_bank #(
        .W(W), .SEQ_LEN(SEQ_LEN), .LFSR_DEG(LFSR_DEG),
        .LFSR_TAPS(LFSR_TAPS), .Q_SEED(Q_SEED), .MW(MW)
    ) u_bank (
        .hist_i(hist_i), .hist_q(hist_q), .metrics(metrics)
    );

    pa_arbiter #(.W(W), .MW(MW)) u_arb (
        .metrics(metrics), .thr(threshold), .hit(arb_hit),
        .win_phase(win_phase), .win_offset(win_offset)
    );

    // A hypothesis set is evaluated once, in the cycle after its word arrived
    assign hit_now    = st_q.fresh && !st_q.locked && !frame_end && arb_hit;
    assign use_phase  = hit_now ? win_phase  : st_q.phase;
    assign use_offset = hit_now ? win_offset : st_q.offset;
    assign ra_en      = in_valid && (hit_now || (st_q.locked && !frame_end));

    always_comb begin
        st_d        = st_q;
        st_d.fresh  = in_valid;
        st_d.det    = hit_now;
        st_d.phase  = use_phase;
        st_d.offset = use_offset;
        if (frame_end) st_d.locked = 1'b0;
        else if (hit_now) st_d.locked = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pa_realign #(.W(W)) u_align (
        .clk(clk), .rst_n(rst_n), .en(ra_en),
        .phase(use_phase), .offset(use_offset),
        .prev_i(hist_i[W-1:0]), .prev_q(hist_q[W-1:0]),
        .new_i(in_i), .new_q(in_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    assign frame_det  = st_q.det;
    assign det_phase  = st_q.phase;
    assign det_offset = st_q.offset;

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_det |=> !frame_det);
    p_hold_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.locked && !frame_end) |=> ($stable(det_phase) && $stable(det_offset)));
    p_det_needs_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_det |-> $past(in_valid, 2));
    p_no_det_after_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_det);
    p_out_needs_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
endmodule

// File: tb/preamble_acq_tb.sv
`timescale 1ns/1ps
module preamble_acq_tb;
    localparam int W     = 32;
    localparam int N     = 64;
    localparam int K     = N / W;
    localparam int DEPTH = K + 1;
    localparam int MW    = $clog2(2 * N) + 2;
    localparam int DEG   = 6;
    localparam logic [DEG-1:0] TAPS  = 6'b110000;
    localparam logic [DEG-1:0] QSEED = 6'b101010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [W-1:0] in_i = '0, in_q = '0;
    logic frame_end = 1'b0;
    logic signed [MW-1:0] threshold = MW'(2 * N - 4);
    logic frame_det, out_valid;
    logic [1:0] det_phase;
    logic [4:0] det_offset;
    logic [W-1:0] out_i, out_q;

    always #4 clk = ~clk;

    preamble_acq #(.W(W), .SEQ_LEN(N), .LFSR_DEG(DEG), .LFSR_TAPS(TAPS), .Q_SEED(QSEED)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .frame_end(frame_end), .threshold(threshold), .frame_det(frame_det),
        .det_phase(det_phase), .det_offset(det_offset), .out_valid(out_valid),
        .out_i(out_i), .out_q(out_q)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int cyc = 0;
    int det_cnt = 0, det_cyc = 0, out_cnt = 0, drv_cyc = 0;
    logic [1:0] det_ph_seen = '0;
    logic [4:0] det_off_seen = '0;
    logic [W-1:0] o_i [0:1023];
    logic [W-1:0] o_q [0:1023];
    logic rf_i [0:N-1];
    logic rf_q [0:N-1];
    logic st_i [0:1023];
    logic st_q [0:1023];
    logic pay_i [0:511];
    logic pay_q [0:511];
    logic [W-1:0] hm_i [0:DEPTH-1];
    logic [W-1:0] hm_q [0:DEPTH-1];
    logic [31:0] rng = 32'h1234_5678;
    int n_words = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (frame_det) begin
            det_cnt = det_cnt + 1;
            det_cyc = cyc;
            det_ph_seen = det_phase;
            det_off_seen = det_offset;
        end
        if (out_valid) begin
            o_i[out_cnt % 1024] = out_i;
            o_q[out_cnt % 1024] = out_q;
            out_cnt = out_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic rbit();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng[0];
    endfunction

    // forward rotation applied k times: (I,Q)->(~Q,I)
    task automatic rotp(input int k, input logic a, input logic b, output logic ra, output logic rb);
        logic t;
        ra = a; rb = b;
        for (int n = 0; n < k; n++) begin
            t = ~rb; rb = ra; ra = t;
        end
    endtask

    // R2 reference generation written from the requirement text
    task automatic gen_refs();
        logic [DEG-1:0] si, sq;
        si = '1; sq = QSEED;
        for (int k = 0; k < N; k++) begin
            rf_i[k] = si[DEG-1];
            rf_q[k] = sq[DEG-1];
            si = {si[DEG-2:0], ^(si & TAPS)};
            sq = {sq[DEG-2:0], ^(sq & TAPS)};
        end
    endtask

    task automatic build(input int ph, input int off, input int pre, input int npay);
        int pos;
        logic a, b;
        n_words = pre + K + 1 + npay;
        pos = 0;
        for (int k = 0; k < pre * W + off; k++) begin
            st_i[pos] = rbit(); st_q[pos] = rbit(); pos++;
        end
        for (int k = 0; k < N; k++) begin
            rotp(ph, rf_i[k], rf_q[k], a, b);
            st_i[pos] = a; st_q[pos] = b; pos++;
        end
        for (int k = 0; k < npay * W; k++) begin
            pay_i[k] = rbit(); pay_q[k] = rbit();
            rotp(ph, pay_i[k], pay_q[k], a, b);
            st_i[pos] = a; st_q[pos] = b; pos++;
        end
        while (pos < n_words * W) begin
            st_i[pos] = rbit(); st_q[pos] = rbit(); pos++;
        end
    endtask

    task automatic drive_word(input logic [W-1:0] wi, input logic [W-1:0] wq);
        in_valid = 1'b1; in_i = wi; in_q = wq;
        for (int d = 0; d < DEPTH - 1; d++) begin
            hm_i[d] = hm_i[d+1]; hm_q[d] = hm_q[d+1];
        end
        hm_i[DEPTH-1] = wi; hm_q[DEPTH-1] = wq;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int c = 0; c < n; c++) @(negedge clk);
    endtask

    task automatic send(input int pre, input bit gaps, input int upto);
        logic [W-1:0] wi, wq;
        for (int w = 0; w < upto; w++) begin
            for (int k = 0; k < W; k++) begin
                wi[W-1-k] = st_i[w*W+k];
                wq[W-1-k] = st_q[w*W+k];
            end
            if (w == pre + K) drv_cyc = cyc;
            drive_word(wi, wq);
            if (gaps) idle(1);
        end
    endtask

    task automatic pulse_end();
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        idle(2);
    endtask

    // Score model of R3/R4 over the bench's own copy of the history
    function automatic int model_score(input int ph, input int off);
        int m, t;
        logic a, b, ci, cq;
        m = 0;
        for (int k = 0; k < N; k++) begin
            t = off + k;
            ci = hm_i[t / W][W-1-(t % W)];
            cq = hm_q[t / W][W-1-(t % W)];
            a = rf_i[k]; b = rf_q[k];
            for (int n = 0; n < ph; n++) begin
                logic tt;
                tt = ~b; b = a; a = tt;
            end
            m += (ci == a) ? 1 : -1;
            m += (cq == b) ? 1 : -1;
        end
        return m;
    endfunction

    task automatic sc_reset();
        chk("R1 frame_det", 64'(frame_det), 64'd0);
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 det_phase", 64'(det_phase), 64'd0);
        chk("R1 det_offset", 64'(det_offset), 64'd0);
        chk("R1 out_i", 64'(out_i), 64'd0);
    endtask

    task automatic sc_acquire(input int ph, input int off, input int pre, input int npay, input bit gaps);
        int d0, o0;
        logic [W-1:0] ei, eq;
        d0 = det_cnt; o0 = out_cnt;
        build(ph, off, pre, npay);
        send(pre, gaps, n_words);
        idle(3);
        chk("R3 one detection", 64'(det_cnt - d0), 64'd1);
        chk("R3 detect timing", 64'(det_cyc - drv_cyc), 64'd2);
        chk("R4 phase", 64'(det_ph_seen), 64'(ph));
        chk("R5 R2 offset", 64'(det_off_seen), 64'(off));
        chk("R10 R9 output count", 64'(out_cnt - o0), 64'(npay));
        for (int j = 0; j < npay; j++) begin
            for (int k = 0; k < W; k++) begin
                ei[W-1-k] = pay_i[j*W+k];
                eq[W-1-k] = pay_q[j*W+k];
            end
            chk("R9 out_i word", 64'(o_i[(o0+j) % 1024]), 64'(ei));
            chk("R9 out_q word", 64'(o_q[(o0+j) % 1024]), 64'(eq));
        end
    endtask

    task automatic sc_locked();
        int d0;
        sc_acquire(1, 9, 1, 2, 1'b0);
        d0 = det_cnt;
        build(3, 2, 1, 2);
        send(1, 1'b0, n_words);
        idle(3);
        chk("R7 no second detection", 64'(det_cnt - d0), 64'd0);
        chk("R7 phase held", 64'(det_phase), 64'd1);
        chk("R7 offset held", 64'(det_offset), 64'd9);
        pulse_end();
    endtask

    task automatic sc_end_race();
        int d0;
        d0 = det_cnt;
        build(0, 4, 1, 1);
        send(1, 1'b0, 1 + K + 1);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        idle(3);
        chk("R8 detection suppressed", 64'(det_cnt - d0), 64'd0);
        sc_acquire(2, 0, 1, 2, 1'b0);
        pulse_end();
    endtask

    task automatic sc_tie(input bit zero);
        int best, bp, bo, sc, d0;
        threshold = MW'(2 * N + 1);
        for (int w = 0; w < DEPTH; w++) drive_word(zero ? '0 : {rbit(), 31'h5a5a_1234}, '0);
        idle(2);
        pulse_end();
        threshold = {1'b1, {(MW-1){1'b0}}};
        d0 = det_cnt;
        drive_word(zero ? '0 : 32'hC3A5_0F96, zero ? '0 : 32'h1E2D_3C4B);
        idle(3);
        best = model_score(0, 0); bp = 0; bo = 0;
        for (int p = 0; p < 4; p++)
            for (int s = 0; s < W; s++) begin
                sc = model_score(p, s);
                if (sc > best) begin best = sc; bp = p; bo = s; end
            end
        chk("R6 detection", 64'(det_cnt - d0), 64'd1);
        chk("R6 winning phase", 64'(det_ph_seen), 64'(bp));
        chk("R6 winning offset", 64'(det_off_seen), 64'(bo));
        pulse_end();
        threshold = MW'(2 * N - 4);
    endtask

    initial begin
        #(8ns * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int d = 0; d < DEPTH; d++) begin hm_i[d] = '0; hm_q[d] = '0; end
        gen_refs();
        idle(3);
        sc_reset();
        rst_n = 1'b1;
        idle(2);
        sc_acquire(0, 0, 2, 3, 1'b0);
        pulse_end();
        sc_acquire(1, 5, 1, 3, 1'b0);
        pulse_end();
        sc_acquire(2, 17, 2, 2, 1'b1);
        pulse_end();
        sc_acquire(3, 31, 1, 3, 1'b0);
        pulse_end();
        sc_locked();
        sc_end_race();
        sc_tie(1'b1);
        sc_tie(1'b0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule